// File: doc/BRIEF.md
# Functional Unit Busy Tracker

This block sits in the issue stage of an in-order core. Each issue slot presents a set of instruction class flags. The block maps those flags onto one functional unit: ALU, multiplier, branch unit, load unit or store unit. It then reports whether that unit can accept the instruction in the current cycle.

When a slot issues, the block marks its unit busy. It also marks busy any unit whose use would conflict with that instruction. A cycle-advance strobe releases the busy state. A multiply is the exception: it keeps the ALU and the branch unit occupied for one further cycle. A second ALU is present when the block is built for more than one issue slot. Slots are evaluated in order within a cycle, so a later slot sees the units taken by an earlier one.

Top module: `fu_busy_tracker`

## Requirements
- R1: A slot's unit is chosen by priority: branch or register-jump selects the branch unit, else mul/div selects the multiplier, else load selects the load unit, else store selects the store unit, else the ALU.
- R2: An ALU-class slot is ready when the main ALU is free, or when the second ALU exists and is free.
- R3: An accepted ALU issue occupies the second ALU when it exists and is free. Otherwise it occupies both the main ALU and the branch unit.
- R4: An accepted branch-unit issue occupies the main ALU, the branch unit and the store unit. The load unit stays free.
- R5: An accepted load or store issue occupies both the load unit and the store unit.
- R6: An accepted multiply occupies the multiplier. At the next cycle advance, the main ALU and the branch unit become busy for exactly one advance interval. Until an advance occurs, that pending hold is kept.
- R7: After reset, every unit is free. A cycle advance frees the multiplier, load unit, store unit and second ALU, and clears the pending hold. Without an advance and without an accepted issue, the busy state is unchanged.
- R8: Slot k is judged against the busy state left by the accepted issues of slots 0..k-1 in the same cycle.
- R9: An issue on a slot that is not ready is ignored: it leaves the busy state untouched. It raises `issue_err` in the following cycle. `issue_err` is low in any cycle following a cycle with no such issue.
- R10: The second ALU exists only when ISSUE_W > 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_branch | input | ISSUE_W | Per slot: conditional branch |
| is_regjump | input | ISSUE_W | Per slot: register-indirect jump |
| is_muldiv | input | ISSUE_W | Per slot: multiply/divide |
| is_load | input | ISSUE_W | Per slot: load |
| is_store | input | ISSUE_W | Per slot: store |
| issue | input | ISSUE_W | Per slot: issue strobe |
| step | input | 1 | Cycle advance: apply the release rule at this edge |
| ready | output | ISSUE_W | Per slot: target unit can accept |
| issue_err | output | 1 | Registered: an issue hit a non-ready unit last cycle |

## Verification
The bench builds two copies of the block. The first uses ISSUE_W = 2, so the second ALU and in-cycle slot chaining are both present. With two slots, the bench can watch one slot's effect on the other within a single cycle. It can also observe an ALU issue spilling onto the main ALU once the second ALU is taken. The second copy uses ISSUE_W = 1 and has no second ALU. This copy is what makes the multiply hold on the ALU visible at an ALU-class slot, and it shows that a lone ALU issue blocks the next one.

// File: rtl/fu_busy_pkg.sv
package fu_busy_pkg;

  typedef enum logic [2:0] {
    FU_ALU = 3'd0,
    FU_MUL = 3'd1,
    FU_BRU = 3'd2,
    FU_LDU = 3'd3,
    FU_STU = 3'd4
  } fu_kind_e;

  // Busy flags of every unit plus the multiply hold request.
  typedef struct packed {
    logic alu;
    logic alu2;
    logic mul;
    logic bru;
    logic ldu;
    logic stu;
    logic mul_pend;
  } busy_t;

  localparam busy_t BUSY_IDLE = '0;

endpackage

// File: rtl/fu_classify.sv
module fu_classify
  import fu_busy_pkg::*;
(
  input  logic     br,
  input  logic     rj,
  input  logic     md,
  input  logic     ld,
  input  logic     st,
  output fu_kind_e kind
);
  // Priority encoder from class flags to a single unit (R1).
  always_comb begin
    if (br || rj)  kind = FU_BRU;
    else if (md)   kind = FU_MUL;
    else if (ld)   kind = FU_LDU;
    else if (st)   kind = FU_STU;
    else           kind = FU_ALU;
  end
endmodule

// File: rtl/fu_issue_slot.sv
module fu_issue_slot
  import fu_busy_pkg::*;
#(
  parameter bit HAS_ALU2 = 1'b1
) (
  input  busy_t    cur,
  input  fu_kind_e kind,
  input  logic     issue,
  output logic     ready,
  output busy_t    nxt
);
  logic alu2_free;

  assign alu2_free = HAS_ALU2 && !cur.alu2;

  always_comb begin
    unique case (kind)
      FU_ALU:  ready = alu2_free || !cur.alu;
      FU_MUL:  ready = !cur.mul;
      FU_BRU:  ready = !cur.bru;
      FU_LDU:  ready = !cur.ldu;
      FU_STU:  ready = !cur.stu;
      default: ready = 1'b0;
    endcase
  end

  // Occupancy applied only when the issue is accepted (R9).
  always_comb begin
    nxt = cur;
    if (issue && ready) begin
      unique case (kind)
        FU_ALU: begin
          if (alu2_free) begin
            nxt.alu2 = 1'b1;
          end else begin
            nxt.alu = 1'b1;
            nxt.bru = 1'b1;
          end
        end
        FU_MUL: begin
          nxt.mul      = 1'b1;
          nxt.mul_pend = 1'b1;
        end
        FU_BRU: begin
          nxt.alu = 1'b1;
          nxt.bru = 1'b1;
          nxt.stu = 1'b1;
        end
        FU_LDU, FU_STU: begin
          nxt.ldu = 1'b1;
          nxt.stu = 1'b1;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/fu_step_rule.sv
module fu_step_rule
  import fu_busy_pkg::*;
(
  input  busy_t cur,
  input  logic  step,
  output busy_t nxt
);
  always_comb begin
    nxt = cur;
    if (step) begin
      nxt.mul      = 1'b0;
      nxt.ldu      = 1'b0;
      nxt.stu      = 1'b0;
      nxt.alu2     = 1'b0;
      nxt.alu      = cur.mul_pend;
      nxt.bru      = cur.mul_pend;
      nxt.mul_pend = 1'b0;
    end
  end
endmodule

// File: rtl/fu_busy_tracker.sv
module fu_busy_tracker
  import fu_busy_pkg::*;
#(
  parameter int ISSUE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ISSUE_W-1:0] is_branch,
  input  logic [ISSUE_W-1:0] is_regjump,
  input  logic [ISSUE_W-1:0] is_muldiv,
  input  logic [ISSUE_W-1:0] is_load,
  input  logic [ISSUE_W-1:0] is_store,
  input  logic [ISSUE_W-1:0] issue,
  input  logic               step,
  output logic [ISSUE_W-1:0] ready,
  output logic               issue_err
);
  localparam bit HAS_ALU2 = (ISSUE_W > 1);

  busy_t busy_q;
  busy_t busy_d;
  busy_t chain [ISSUE_W+1];

  assign chain[0] = busy_q;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    fu_kind_e kind;

    fu_classify u_cls (
      .br   (is_branch[s]),
      .rj   (is_regjump[s]),
      .md   (is_muldiv[s]),
      .ld   (is_load[s]),
      .st   (is_store[s]),
      .kind (kind)
    );

    fu_issue_slot #(.HAS_ALU2(HAS_ALU2)) u_slot (
      .cur   (chain[s]),
      .kind  (kind),
      .issue (issue[s]),
      .ready (ready[s]),
      .nxt   (chain[s+1])
    );
  end

  fu_step_rule u_step (
    .cur  (chain[ISSUE_W]),
    .step (step),
    .nxt  (busy_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= BUSY_IDLE;
      issue_err <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      issue_err <= |(issue & ~ready);
    end
  end
endmodule

// File: rtl/fu_busy_tracker_chk.sv
module fu_busy_tracker_chk
  import fu_busy_pkg::*;
#(
  parameter int ISSUE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ISSUE_W-1:0] is_branch,
  input logic [ISSUE_W-1:0] is_regjump,
  input logic [ISSUE_W-1:0] is_muldiv,
  input logic [ISSUE_W-1:0] is_load,
  input logic [ISSUE_W-1:0] is_store,
  input logic [ISSUE_W-1:0] issue,
  input logic               step,
  input logic [ISSUE_W-1:0] ready,
  input logic               issue_err,
  input busy_t              busy_q
);
  p_err_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (|(issue & ~ready)) |=> issue_err);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(issue & ~ready)) |=> !issue_err);

  p_step_clear_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> (!busy_q.mul && !busy_q.ldu && !busy_q.stu && !busy_q.alu2 && !busy_q.mul_pend));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step && issue == '0) |=> $stable(busy_q));

  p_mul_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (issue[0] && ready[0] && is_muldiv[0] && !is_branch[0] && !is_regjump[0] && step)
    |=> ((is_branch[0] || is_regjump[0]) -> !ready[0]));

  p_ldst_r5: assert property (@(posedge clk) disable iff (rst)
    (issue[0] && ready[0] && is_load[0] && !is_muldiv[0] && !is_branch[0] && !is_regjump[0] && !step)
    |=> ((is_store[0] && !is_load[0] && !is_muldiv[0] && !is_branch[0] && !is_regjump[0]) -> !ready[0]));

  if (ISSUE_W == 1) begin : g_single
    p_no_alu2_r10: assert property (@(posedge clk) disable iff (rst) !busy_q.alu2);
  end
endmodule

bind fu_busy_tracker fu_busy_tracker_chk #(.ISSUE_W(ISSUE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .is_branch  (is_branch),
  .is_regjump (is_regjump),
  .is_muldiv  (is_muldiv),
  .is_load    (is_load),
  .is_store   (is_store),
  .issue      (issue),
  .step       (step),
  .ready      (ready),
  .issue_err  (issue_err),
  .busy_q     (busy_q)
);

// File: tb/fu_busy_tracker_tb.sv
module fu_busy_tracker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0] br, rj, md, ld, st, iss, rdy;
  logic       stp, err;

  logic s_br, s_rj, s_md, s_ld, s_st, s_iss, s_stp, s_rdy, s_err;

  int tests = 0;
  int fails = 0;

  fu_busy_tracker #(.ISSUE_W(2)) u_dut (
    .clk(clk), .rst(rst), .is_branch(br), .is_regjump(rj), .is_muldiv(md),
    .is_load(ld), .is_store(st), .issue(iss), .step(stp), .ready(rdy), .issue_err(err)
  );

  fu_busy_tracker #(.ISSUE_W(1)) u_dut_single (
    .clk(clk), .rst(rst), .is_branch(s_br), .is_regjump(s_rj), .is_muldiv(s_md),
    .is_load(s_ld), .is_store(s_st), .issue(s_iss), .step(s_stp), .ready(s_rdy),
    .issue_err(s_err)
  );

  // Class codes: 0 alu, 1 branch, 2 regjump, 3 mul, 4 load, 5 store
  task automatic put(input int s, input int cls, input logic go);
    br[s] = (cls == 1); rj[s] = (cls == 2); md[s] = (cls == 3);
    ld[s] = (cls == 4); st[s] = (cls == 5); iss[s] = go;
  endtask

  task automatic sput(input int cls, input logic go);
    s_br = (cls == 1); s_rj = (cls == 2); s_md = (cls == 3);
    s_ld = (cls == 4); s_st = (cls == 5); s_iss = go;
  endtask

  task automatic idle();
    put(0, 0, 1'b0); put(1, 0, 1'b0); stp = 1'b0;
    sput(0, 1'b0); s_stp = 1'b0;
  endtask

  task automatic check(input logic got, input logic exp, input string req, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Inputs are changed on the falling edge; combinational results settle 1 ns later.
  task automatic settle(); #1; endtask
  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic t_reset();
    idle();
    for (int c = 0; c < 6; c++) begin
      put(0, c, 1'b0); settle();
      check(rdy[0], 1'b1, "R7", $sformatf("class %0d ready after reset", c));
    end
    check(err, 1'b0, "R7", "no error after reset");
  endtask

  task automatic t_alu_pair();
    idle();
    put(0, 0, 1'b1); put(1, 0, 1'b1); settle();
    check(rdy[0], 1'b1, "R2", "slot0 alu ready");
    check(rdy[1], 1'b1, "R8", "slot1 alu uses main alu after slot0 took second");
    tick(); idle();
    put(0, 0, 1'b0); settle();
    check(rdy[0], 1'b0, "R2", "both alus busy");
    put(0, 1, 1'b0); settle();
    check(rdy[0], 1'b0, "R3", "main alu issue blocks branch");
    put(0, 4, 1'b0); settle();
    check(rdy[0], 1'b1, "R3", "load free after alu issues");
    stp = 1'b1; tick(); idle();
    put(0, 0, 1'b0); settle();
    check(rdy[0], 1'b1, "R7", "alu free after advance");
    put(0, 1, 1'b0); settle();
    check(rdy[0], 1'b1, "R7", "branch free after advance");
  endtask

  task automatic t_branch_chain();
    idle();
    put(0, 1, 1'b1);
    put(1, 0, 1'b0); settle();
    check(rdy[1], 1'b1, "R2", "alu ready through second alu after branch");
    put(1, 5, 1'b0); settle();
    check(rdy[1], 1'b0, "R4", "store blocked by branch in same cycle");
    put(1, 4, 1'b0); settle();
    check(rdy[1], 1'b1, "R4", "load free after branch");
    put(1, 2, 1'b0); settle();
    check(rdy[1], 1'b0, "R8", "regjump blocked by earlier branch");
    stp = 1'b1; tick(); idle();
  endtask

  task automatic t_ldst();
    idle();
    put(0, 4, 1'b1); put(1, 5, 1'b0); settle();
    check(rdy[1], 1'b0, "R5", "store blocked by load");
    put(1, 3, 1'b0); settle();
    check(rdy[1], 1'b1, "R5", "mul unaffected by load");
    tick(); idle();
    put(0, 4, 1'b0); settle();
    check(rdy[0], 1'b0, "R5", "load still busy without advance");
    stp = 1'b1; tick(); idle();
    put(0, 5, 1'b0); settle();
    check(rdy[0], 1'b1, "R7", "store free after advance");
  endtask

  task automatic t_mul();
    idle();
    put(0, 3, 1'b1); stp = 1'b1; sput(3, 1'b1); s_stp = 1'b1;
    tick(); idle();
    put(0, 3, 1'b0); settle();
    check(rdy[0], 1'b1, "R6", "mul free after advance");
    put(0, 1, 1'b0); settle();
    check(rdy[0], 1'b0, "R6", "branch held by mul");
    put(0, 0, 1'b0); settle();
    check(rdy[0], 1'b1, "R6", "dual: alu via second alu during hold");
    sput(0, 1'b0); settle();
    check(s_rdy, 1'b0, "R6", "single: alu held by mul");
    stp = 1'b1; s_stp = 1'b1; tick(); idle();
    put(0, 1, 1'b0); sput(0, 1'b0); settle();
    check(rdy[0], 1'b1, "R6", "branch released after one interval");
    check(s_rdy, 1'b1, "R6", "single: alu released");
    // pending hold kept across cycles without advance
    put(0, 3, 1'b1); tick(); idle(); tick();
    put(0, 1, 1'b0); settle();
    check(rdy[0], 1'b1, "R6", "no hold before advance");
    put(0, 3, 1'b0); settle();
    check(rdy[0], 1'b0, "R6", "mul busy before advance");
    stp = 1'b1; tick(); idle();
    put(0, 1, 1'b0); settle();
    check(rdy[0], 1'b0, "R6", "hold applied at later advance");
    stp = 1'b1; tick(); idle();
  endtask

  task automatic t_priority();
    idle();
    br[0] = 1'b1; md[0] = 1'b1; ld[0] = 1'b1; iss[0] = 1'b1;
    put(1, 3, 1'b0); settle();
    check(rdy[1], 1'b1, "R1", "branch+mul+load picks branch: mul free");
    put(1, 5, 1'b0); settle();
    check(rdy[1], 1'b0, "R1", "branch+mul+load picks branch: store blocked");
    stp = 1'b1; tick(); idle();
    md[0] = 1'b1; ld[0] = 1'b1; iss[0] = 1'b1;
    put(1, 4, 1'b0); settle();
    check(rdy[1], 1'b1, "R1", "mul+load picks mul: load free");
    put(1, 3, 1'b0); settle();
    check(rdy[1], 1'b0, "R1", "mul+load picks mul: mul blocked");
    stp = 1'b1; tick(); idle(); stp = 1'b1; tick(); idle();
    put(0, 2, 1'b1); put(1, 5, 1'b0); settle();
    check(rdy[1], 1'b0, "R1", "regjump acts as branch");
    stp = 1'b1; tick(); idle();
  endtask

  task automatic t_err();
    idle();
    put(0, 0, 1'b1); put(1, 0, 1'b1); tick(); idle();
    check(err, 1'b0, "R9", "no error on accepted issues");
    put(0, 1, 1'b1); put(1, 5, 1'b0); settle();
    check(rdy[0], 1'b0, "R9", "branch not ready");
    check(rdy[1], 1'b1, "R9", "rejected branch does not take store");
    tick(); idle(); settle();
    check(err, 1'b1, "R9", "error flagged");
    put(0, 5, 1'b0); settle();
    check(rdy[0], 1'b1, "R9", "store still free after rejected issue");
    tick();
    check(err, 1'b0, "R9", "error clears");
    stp = 1'b1; tick(); idle();
  endtask

  task automatic t_single_alu();
    idle();
    sput(0, 1'b1); tick(); idle();
    sput(0, 1'b0); settle();
    check(s_rdy, 1'b0, "R10", "single: one alu only");
    sput(1, 1'b0); settle();
    check(s_rdy, 1'b0, "R10", "single: alu issue took branch");
    s_stp = 1'b1; tick(); idle();
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_alu_pair();
    t_branch_chain();
    t_ldst();
    t_mul();
    t_priority();
    t_err();
    t_single_alu();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule